// File: doc/BRIEF.md
# Systolic Sorting Queue

This block sorts a batch of unsigned keys without RAM and without any global search. Keys come in one per clock on a valid/key input pair. They are stored in a linear chain of register cells, and each cell exchanges values only with the cell before it and the cell after it. On an insert, every occupied cell that holds a larger key passes that key one place further from the output. The new key then drops into the gap this opens. As a result, the chain always holds its keys in ascending order, with the smallest key in the cell at the output end.

When the whole batch has been loaded, the user holds the drain command high. The chain then moves one place toward the output on every clock, and each key leaves on a registered valid/key output, smallest first. The block reports its occupancy as a count and as full and empty flags. It refuses new keys once every cell is occupied.

Top module: `pq_sorter`

## Requirements
- R1: While reset (rst_n low) is asserted, and on the first clock after it is released, count is 0, empty is 1, full is 0 and out_valid is 0.
- R2: On a clock where in_valid is 1, drain is 0 and full is 0, the key on in_key is stored and count increases by one. One key can be stored on every clock.
- R3: The stored keys always stay in ascending order from the output end. Draining a batch therefore returns all of its keys in non-decreasing unsigned order, including the extreme values 0 and 255, and duplicate keys each come out once.
- R4: On a clock where drain is 1 and count is not zero, out_valid is 1 on the next cycle. At that point out_key is the smallest stored key and count has decreased by one.
- R5: On a clock where drain is 1 and count is 0, out_valid is 0 on the next cycle and count stays 0.
- R6: When count equals DEPTH (48), full is 1. An insert attempted while full is refused: count does not change, and the refused key never appears in the drained output.
- R7: When drain and in_valid are both 1 on the same clock, the drain is carried out and the input key is discarded. It never appears in the drained output.
- R8: empty is 1 exactly when count is 0. out_valid is 0 on every cycle that does not follow a drain of a non-empty queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A key is offered on in_key |
| in_key | input | KEY_W (8) | Unsigned key to insert |
| drain | input | 1 | Remove the smallest key this cycle |
| out_valid | output | 1 | out_key carries a drained key |
| out_key | output | KEY_W (8) | Drained key, registered |
| full | output | 1 | All DEPTH cells occupied |
| empty | output | 1 | No cell occupied |
| count | output | $clog2(DEPTH+1) (6) | Number of stored keys |

## Verification
The assertions assume that all inputs are driven to known values once reset is released. They also assume that the drain command wins over an insert when both arrive on the same cycle, so occupancy changes by at most one per clock. The bench drives every input on the falling clock edge, with in_valid and drain never left undefined. Inserts beyond capacity and inserts that collide with a drain are issued on purpose, so the bookkeeping assertions are exercised at the capacity limit and at the drain/insert collision.

// File: rtl/pq_pkg.sv
package pq_pkg;

  // A cell gives up its place to an incoming key when it is empty or
  // when its key is strictly larger. A key equal to the stored one is
  // placed behind it, so equal keys keep their arrival order.
  function automatic logic displaces(input logic       stored_valid,
                                     input logic [7:0] stored_key,
                                     input logic [7:0] incoming_key);
    return (!stored_valid) || (stored_key > incoming_key);
  endfunction

  // Next occupancy value, given the insert and drain events of a cycle.
  function automatic int unsigned next_count(input int unsigned cur,
                                             input logic        ins,
                                             input logic        drn);
    if (drn)      return cur - 1;
    else if (ins) return cur + 1;
    else          return cur;
  endfunction

endpackage

// File: rtl/pq_cell.sv
module pq_cell #(
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic             drn_en,
  input  logic [KEY_W-1:0] new_key,
  input  logic             prev_take,
  input  logic             prev_valid,
  input  logic [KEY_W-1:0] prev_key,
  input  logic             next_valid,
  input  logic [KEY_W-1:0] next_key,
  output logic             take,
  output logic             cell_valid,
  output logic [KEY_W-1:0] cell_key
);

  logic [7:0] cmp_stored;
  logic [7:0] cmp_new;

  assign cmp_stored = 8'(cell_key);
  assign cmp_new    = 8'(new_key);
  assign take       = pq_pkg::displaces(cell_valid, cmp_stored, cmp_new);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cell_valid <= 1'b0;
      cell_key   <= '0;
    end else if (drn_en) begin
      cell_valid <= next_valid;
      cell_key   <= next_key;
    end else if (ins_en && take) begin
      if (prev_take) begin
        cell_valid <= prev_valid;
        cell_key   <= prev_key;
      end else begin
        cell_valid <= 1'b1;
        cell_key   <= new_key;
      end
    end
  end

endmodule

// File: rtl/pq_occupancy.sv
module pq_occupancy #(
  parameter int DEPTH   = 48,
  parameter int COUNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ins_fire,
  input  logic               drn_fire,
  output logic [COUNT_W-1:0] count,
  output logic               full,
  output logic               empty
);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= COUNT_W'(pq_pkg::next_count(32'(count), ins_fire, drn_fire));
  end

  assign full  = (count == COUNT_W'(DEPTH));
  assign empty = (count == '0);

endmodule

// File: rtl/pq_out_stage.sv
module pq_out_stage #(
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drn_fire,
  input  logic [KEY_W-1:0] head_key,
  output logic             out_valid,
  output logic [KEY_W-1:0] out_key
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_key   <= '0;
    end else begin
      out_valid <= drn_fire;
      if (drn_fire) out_key <= head_key;
    end
  end

endmodule

// File: rtl/pq_sorter.sv
module pq_sorter #(
  parameter int KEY_W   = 8,
  parameter int DEPTH   = 48,
  parameter int COUNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [KEY_W-1:0]   in_key,
  input  logic               drain,
  output logic               out_valid,
  output logic [KEY_W-1:0]   out_key,
  output logic               full,
  output logic               empty,
  output logic [COUNT_W-1:0] count
);

  // Named internal events, brought out for the checker
  logic ins_fire;
  logic drn_fire;
  logic ins_refused;

  logic [DEPTH-1:0]            cell_valid;
  logic [DEPTH-1:0]            take_vec;
  logic [DEPTH-1:0][KEY_W-1:0] cell_key;

  logic [DEPTH-1:0]            prev_take_vec;
  logic [DEPTH-1:0]            prev_valid_vec;
  logic [DEPTH-1:0][KEY_W-1:0] prev_key_vec;
  logic [DEPTH-1:0]            next_valid_vec;
  logic [DEPTH-1:0][KEY_W-1:0] next_key_vec;

  assign drn_fire    = drain && !empty;
  assign ins_fire    = in_valid && !drain && !full;
  assign ins_refused = in_valid && !drain && full;

  // Neighbour wiring: toward the output end (index 0) and away from it
  assign prev_take_vec  = {take_vec[DEPTH-2:0], 1'b0};
  assign prev_valid_vec = {cell_valid[DEPTH-2:0], 1'b0};
  assign prev_key_vec   = {cell_key[DEPTH-2:0], {KEY_W{1'b0}}};
  assign next_valid_vec = {1'b0, cell_valid[DEPTH-1:1]};
  assign next_key_vec   = {{KEY_W{1'b0}}, cell_key[DEPTH-1:1]};

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    pq_cell #(.KEY_W(KEY_W)) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .ins_en     (ins_fire),
      .drn_en     (drn_fire),
      .new_key    (in_key),
      .prev_take  (prev_take_vec[i]),
      .prev_valid (prev_valid_vec[i]),
      .prev_key   (prev_key_vec[i]),
      .next_valid (next_valid_vec[i]),
      .next_key   (next_key_vec[i]),
      .take       (take_vec[i]),
      .cell_valid (cell_valid[i]),
      .cell_key   (cell_key[i])
    );
  end

  pq_occupancy #(.DEPTH(DEPTH), .COUNT_W(COUNT_W)) u_occ (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_fire (ins_fire),
    .drn_fire (drn_fire),
    .count    (count),
    .full     (full),
    .empty    (empty)
  );

  pq_out_stage #(.KEY_W(KEY_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .drn_fire  (drn_fire),
    .head_key  (cell_key[0]),
    .out_valid (out_valid),
    .out_key   (out_key)
  );

endmodule

// File: rtl/pq_sorter_chk.sv
module pq_sorter_chk #(
  parameter int KEY_W   = 8,
  parameter int DEPTH   = 48,
  parameter int COUNT_W = $clog2(DEPTH + 1)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic                        drain,
  input logic                        out_valid,
  input logic [KEY_W-1:0]            out_key,
  input logic                        full,
  input logic                        empty,
  input logic [COUNT_W-1:0]          count,
  input logic                        ins_fire,
  input logic                        drn_fire,
  input logic                        ins_refused,
  input logic [DEPTH-1:0]            cell_valid,
  input logic [DEPTH-1:0][KEY_W-1:0] cell_key
);

  // R2
  insert_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !drain && !full) |=> (count == $past(count) + 1'b1));

  // R3
  for (genvar i = 0; i < DEPTH - 1; i++) begin : g_ord
    sorted_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cell_valid[i+1] |-> (cell_valid[i] && (cell_key[i] <= cell_key[i+1])));
  end

  // R3
  out_not_above_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cell_valid[0]) |-> (out_key <= cell_key[0]));

  // R4
  drain_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && !empty) |=> (out_valid && (count == $past(count) - 1'b1)));

  // R5
  drain_empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && empty) |=> (!out_valid && empty));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_refused |=> $stable(count) && $stable(cell_valid));

  // R7
  drain_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && in_valid) |-> !ins_fire);

  // R8
  occupancy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cell_valid) == int'(count)) && (empty == (count == '0)));

  // R8
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drn_fire |=> !out_valid);

  // R6
  full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full == (count == COUNT_W'(DEPTH)));

endmodule

bind pq_sorter pq_sorter_chk #(.KEY_W(KEY_W), .DEPTH(DEPTH), .COUNT_W(COUNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .drain       (drain),
  .out_valid   (out_valid),
  .out_key     (out_key),
  .full        (full),
  .empty       (empty),
  .count       (count),
  .ins_fire    (ins_fire),
  .drn_fire    (drn_fire),
  .ins_refused (ins_refused),
  .cell_valid  (cell_valid),
  .cell_key    (cell_key)
);

// File: tb/sim_pq_sorter.sv
module sim_pq_sorter;

  localparam int KEY_W = 8;
  localparam int DEPTH = 48;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int NVEC  = 16;

  // Stimulus order and the hand-sorted result of the same batch
  localparam logic [7:0] VEC_IN [NVEC] = '{8'h5A, 8'h03, 8'hFF, 8'h00, 8'h77, 8'h03, 8'h40, 8'hC8,
                                           8'h11, 8'h9E, 8'h77, 8'h01, 8'hE0, 8'h2B, 8'h80, 8'h3C};
  localparam logic [7:0] VEC_EXP[NVEC] = '{8'h00, 8'h01, 8'h03, 8'h03, 8'h11, 8'h2B, 8'h3C, 8'h40,
                                           8'h5A, 8'h77, 8'h77, 8'h80, 8'h9E, 8'hC8, 8'hE0, 8'hFF};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [KEY_W-1:0] in_key = '0;
  logic            drain = 1'b0;
  logic            out_valid;
  logic [KEY_W-1:0] out_key;
  logic            full;
  logic            empty;
  logic [CW-1:0]   count;

  int checks = 0;
  int failures = 0;
  logic            got_v [DEPTH];
  logic [KEY_W-1:0] got_k [DEPTH];

  always #2 clk = ~clk;

  pq_sorter #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_key(in_key), .drain(drain),
    .out_valid(out_valid), .out_key(out_key), .full(full), .empty(empty), .count(count)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic push(input logic [7:0] k);
    in_valid = 1'b1;
    in_key   = k;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pull(input int n);
    drain = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      got_v[i] = out_valid;
      got_k[i] = out_key;
      if (i == n - 1) drain = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: values while reset is held
    check("R1 count", int'(count), 0);
    check("R1 empty", int'(empty), 1);
    check("R1 full", int'(full), 0);
    check("R1 out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after release", int'(out_valid), 0);

    // R5: drain while empty
    pull(1);
    check("R5 out_valid", int'(got_v[0]), 0);
    check("R5 count", int'(count), 0);

    // R2/R3: vector table, one key per clock
    for (int i = 0; i < NVEC; i++) push(VEC_IN[i]);
    check("R2 count", int'(count), NVEC);
    check("R8 empty low", int'(empty), 0);
    pull(NVEC);
    for (int i = 0; i < NVEC; i++) begin
      check("R4 out_valid", int'(got_v[i]), 1);
      check("R3 order", int'(got_k[i]), int'(VEC_EXP[i]));
    end
    @(negedge clk);
    check("R8 out_valid idle", int'(out_valid), 0);
    check("R8 empty", int'(empty), 1);

    // R4: single drain decrements count by one
    push(8'd9);
    push(8'd4);
    pull(1);
    check("R4 first key", int'(got_k[0]), 4);
    check("R4 count", int'(count), 1);
    pull(1);
    check("R4 last key", int'(got_k[0]), 9);

    // R6: fill to capacity, then attempt one more insert
    for (int i = 0; i < DEPTH; i++) push(8'((DEPTH - 1 - i) * 5 + 10));
    check("R6 count", int'(count), DEPTH);
    check("R6 full", int'(full), 1);
    push(8'd1);
    check("R6 refused count", int'(count), DEPTH);
    pull(DEPTH);
    for (int i = 0; i < DEPTH; i++) check("R6 drained key", int'(got_k[i]), i * 5 + 10);
    check("R6 full cleared", int'(full), 0);
    check("R6 empty", int'(empty), 1);

    // R7: drain and insert in the same cycle
    push(8'd50);
    push(8'd60);
    push(8'd70);
    in_valid = 1'b1;
    in_key   = 8'd5;
    drain    = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    drain    = 1'b0;
    check("R7 out_valid", int'(out_valid), 1);
    check("R7 out_key", int'(out_key), 50);
    check("R7 count", int'(count), 2);
    pull(2);
    check("R7 next key", int'(got_k[0]), 60);
    check("R7 last key", int'(got_k[1]), 70);
    check("R7 empty", int'(empty), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule